// File: doc/BRIEF.md
# Dual-Port Semaphore Flag Unit

This block holds a small bank of lock tokens that two ports share. Both ports run on one clock. Each port has its own select and enable pins, so both can act on the tokens in the same cycle. There are eight tokens. A port picks one with the low three bits of its address. Writes use only data bit 0. The value the port reads is shown on every bit of its read bus.

The tokens carry ownership. A free token reads 1 from both sides. To request a token, a port writes 0 to it. It then reads the token back to learn whether it won. The winner reads 0 and the other side reads 1. Only the owner can free the token, by writing 1. A write is committed on the cycle in which the port's read/write line is first seen high after having been low.

Each side can place an illegal combination on its pins: token select active while its memory enable is also asserted. Such an access is refused, leaves every token as it was, and raises a one-cycle error pulse on that side.

Top module: `sem_flag_unit`

## Requirements
- R1: Eight tokens are indexed by address bits 2:0 of the accessing port. Higher address bits have no effect, and each token keeps its own state.
- R2: After reset every token is free. Both ports read 1 from every token, and both error outputs are low.
- R3: A write takes its value from data bit 0 only. Data bits 15:1 have no effect.
- R4: A port reads when sem_n=0, mem_en_n=1, rw=1 and oe_n=0. Its rdata then shows the token as seen from that side on all 16 bits. In every other case rdata is 0.
- R5: A write is committed only in a cycle where the access is valid (sem_n=0, mem_en_n=1), rw=1 now and rw was 0 in the previous cycle. Otherwise no token changes.
- R6: Writing 0 to a free token gives it to the writing port. That port then reads 0 from it and the other port reads 1.
- R7: A token is released only when its owner writes 1. A write of 1 from the non-owner has no effect. A write of 0 to a token that is already held, by either port, also has no effect.
- R8: If both ports request the same free token in the same cycle, the left port gets it. Every write decision uses the token state from before that cycle, so a release and a request of the same token in one cycle leave it free.
- R9: An access with sem_n=0 and mem_en_n=0 changes no token. The first cycle of such an access raises err high for exactly one cycle after the clock edge. err stays low for the rest of that access.
- R10: The two ports work independently. Requests to different tokens in the same cycle are both granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| l_sem_n | input | 1 | Left token select, active low |
| l_mem_en_n | input | 1 | Left memory enable, active low (must be high for token access) |
| l_rw | input | 1 | Left read/write: 1 read, rising edge commits a write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | 13 | Left address; bits 2:0 pick the token |
| l_wdata | input | 16 | Left write data; bit 0 used |
| l_rdata | output | 16 | Left read data |
| l_err | output | 1 | Left illegal-access pulse |
| r_sem_n | input | 1 | Right token select, active low |
| r_mem_en_n | input | 1 | Right memory enable, active low |
| r_rw | input | 1 | Right read/write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | 13 | Right address; bits 2:0 pick the token |
| r_wdata | input | 16 | Right write data; bit 0 used |
| r_rdata | output | 16 | Right read data |
| r_err | output | 1 | Right illegal-access pulse |

## Verification
Both ports can commit a write to the same token in one clock. This is either two requests racing for a free token or a release on one side meeting a request on the other. The stimulus table lines up both read/write rising edges on the same cycle for the same token. The result is then judged from both sides on the next cycle by reading the token back. A bound property also checks that a double request on a free token ends with the left port as owner.

// File: rtl/sem_pkg.sv
`timescale 1ns/1ps
package sem_pkg;
  typedef enum logic [1:0] {
    OWN_FREE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_t;
endpackage

// File: rtl/sem_rst_sync.sv
`timescale 1ns/1ps
module sem_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sem_port_ctrl.sv
`timescale 1ns/1ps
module sem_port_ctrl #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 13,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sem_n,
  input  logic              mem_en_n,
  input  logic              rw,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              view,
  output logic [IDX_W-1:0]  idx,
  output logic              wr_evt,
  output logic              wr_val,
  output logic [DATA_W-1:0] rdata,
  output logic              err
);
  logic access_ok, access_bad, rd_en;
  logic rw_q, rw_d;
  logic bad_q, bad_d;
  logic err_q, err_d;
  logic unused_bits;

  assign access_ok  = !sem_n && mem_en_n;
  assign access_bad = !sem_n && !mem_en_n;

  always_comb begin
    rw_d  = rw;
    bad_d = access_bad;
    err_d = access_bad && !bad_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rw_q  <= 1'b1;
      bad_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      rw_q  <= rw_d;
      bad_q <= bad_d;
      err_q <= err_d;
    end
  end

  assign idx    = addr[IDX_W-1:0];
  assign wr_evt = access_ok && rw && !rw_q;
  assign wr_val = wdata[0];
  assign rd_en  = access_ok && rw && !oe_n;
  assign rdata  = rd_en ? {DATA_W{view}} : '0;
  assign err    = err_q;

  assign unused_bits = ^{addr[ADDR_W-1:IDX_W], wdata[DATA_W-1:1]};
endmodule

// File: rtl/sem_flag_cell.sv
`timescale 1ns/1ps
module sem_flag_cell
  import sem_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   l_req,
  input  logic   l_rel,
  input  logic   r_req,
  input  logic   r_rel,
  output owner_t own
);
  owner_t own_q, own_d;
  logic   upd_en;

  assign upd_en = l_req || l_rel || r_req || r_rel;

  always_comb begin
    own_d = own_q;
    case (own_q)
      OWN_FREE: begin
        if (l_req)      own_d = OWN_LEFT;
        else if (r_req) own_d = OWN_RIGHT;
      end
      OWN_LEFT:  if (l_rel) own_d = OWN_FREE;
      OWN_RIGHT: if (r_rel) own_d = OWN_FREE;
      default:   own_d = OWN_FREE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      own_q <= OWN_FREE;
    else if (upd_en) own_q <= own_d;
  end

  assign own = own_q;
endmodule

// File: rtl/sem_flag_unit.sv
`timescale 1ns/1ps
module sem_flag_unit
  import sem_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 13,
  parameter int FLAG_CNT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_sem_n,
  input  logic              l_mem_en_n,
  input  logic              l_rw,
  input  logic              l_oe_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_err,
  input  logic              r_sem_n,
  input  logic              r_mem_en_n,
  input  logic              r_rw,
  input  logic              r_oe_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_err
);
  localparam int IDX_W = $clog2(FLAG_CNT);

  logic                  rst_sync_n;
  logic [IDX_W-1:0]      l_idx, r_idx;
  logic                  l_wev, r_wev, l_wval, r_wval;
  logic                  l_view, r_view;
  owner_t [FLAG_CNT-1:0] own_q;

  sem_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  sem_port_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_left (
    .clk(clk), .rst_n(rst_sync_n),
    .sem_n(l_sem_n), .mem_en_n(l_mem_en_n), .rw(l_rw), .oe_n(l_oe_n),
    .addr(l_addr), .wdata(l_wdata), .view(l_view),
    .idx(l_idx), .wr_evt(l_wev), .wr_val(l_wval),
    .rdata(l_rdata), .err(l_err)
  );

  sem_port_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_right (
    .clk(clk), .rst_n(rst_sync_n),
    .sem_n(r_sem_n), .mem_en_n(r_mem_en_n), .rw(r_rw), .oe_n(r_oe_n),
    .addr(r_addr), .wdata(r_wdata), .view(r_view),
    .idx(r_idx), .wr_evt(r_wev), .wr_val(r_wval),
    .rdata(r_rdata), .err(r_err)
  );

  for (genvar g = 0; g < FLAG_CNT; g++) begin : g_flag
    logic l_hit, r_hit;
    assign l_hit = l_wev && (l_idx == IDX_W'(g));
    assign r_hit = r_wev && (r_idx == IDX_W'(g));

    sem_flag_cell u_cell (
      .clk(clk), .rst_n(rst_sync_n),
      .l_req(l_hit && !l_wval), .l_rel(l_hit && l_wval),
      .r_req(r_hit && !r_wval), .r_rel(r_hit && r_wval),
      .own(own_q[g])
    );
  end

  assign l_view = (own_q[l_idx] != OWN_LEFT);
  assign r_view = (own_q[r_idx] != OWN_RIGHT);
endmodule

// File: rtl/sem_flag_unit_chk.sv
`timescale 1ns/1ps
module sem_flag_unit_chk
  import sem_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 13,
  parameter int FLAG_CNT = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  l_sem_n,
  input logic                  l_mem_en_n,
  input logic                  l_rw,
  input logic                  l_oe_n,
  input logic [ADDR_W-1:0]     l_addr,
  input logic [DATA_W-1:0]     l_wdata,
  input logic [DATA_W-1:0]     l_rdata,
  input logic                  l_err,
  input logic                  r_sem_n,
  input logic                  r_mem_en_n,
  input logic                  r_rw,
  input logic                  r_oe_n,
  input logic [ADDR_W-1:0]     r_addr,
  input logic [DATA_W-1:0]     r_wdata,
  input logic [DATA_W-1:0]     r_rdata,
  input logic                  r_err,
  input owner_t [FLAG_CNT-1:0] own
);
  localparam int IDX_W = $clog2(FLAG_CNT);

  logic l_ok, r_ok, l_bad, r_bad, l_rd, r_rd, armed_q;
  logic unused_chk;

  assign l_ok  = !l_sem_n && l_mem_en_n;
  assign r_ok  = !r_sem_n && r_mem_en_n;
  assign l_bad = !l_sem_n && !l_mem_en_n;
  assign r_bad = !r_sem_n && !r_mem_en_n;
  assign l_rd  = l_ok && l_rw && !l_oe_n;
  assign r_rd  = r_ok && r_rw && !r_oe_n;
  assign unused_chk = ^{l_wdata[DATA_W-1:1], r_wdata[DATA_W-1:1],
                        l_addr[ADDR_W-1:IDX_W], r_addr[ADDR_W-1:IDX_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  assert_rdata_uniform_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (l_rdata == '0 || l_rdata == '1) && (r_rdata == '0 || r_rdata == '1));

  assert_rdata_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_rd |-> l_rdata == '0) and (!r_rd |-> r_rdata == '0));

  assert_single_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (l_rd && r_rd && l_addr[IDX_W-1:0] == r_addr[IDX_W-1:0])
      |-> !(l_rdata[0] == 1'b0 && r_rdata[0] == 1'b0));

  assert_no_edge_no_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !((l_ok && l_rw && !$past(l_rw)) || (r_ok && r_rw && !$past(r_rw)))
      |=> $stable(own));

  assert_left_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && l_ok && l_rw && !$past(l_rw) && r_ok && r_rw && !$past(r_rw)
     && l_addr[IDX_W-1:0] == r_addr[IDX_W-1:0] && !l_wdata[0] && !r_wdata[0]
     && own[l_addr[IDX_W-1:0]] == OWN_FREE)
      |=> own[$past(l_addr[IDX_W-1:0])] == OWN_LEFT);

  assert_err_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (l_err |=> !l_err) and (r_err |=> !r_err));

  assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (l_err |-> $past(l_bad)) and (r_err |-> $past(r_bad)));

  assert_bad_no_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((l_bad || l_sem_n) && (r_bad || r_sem_n)) |=> $stable(own));
endmodule

bind sem_flag_unit sem_flag_unit_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FLAG_CNT(FLAG_CNT)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n),
  .l_sem_n(l_sem_n), .l_mem_en_n(l_mem_en_n), .l_rw(l_rw), .l_oe_n(l_oe_n),
  .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_err(l_err),
  .r_sem_n(r_sem_n), .r_mem_en_n(r_mem_en_n), .r_rw(r_rw), .r_oe_n(r_oe_n),
  .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_err(r_err),
  .own(own_q)
);

// File: tb/sem_flag_unit_test.sv
`timescale 1ns/1ps
module sem_flag_unit_test;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 13;

  localparam logic [3:0] M_RD   = 4'b0110; // sem_n,mem_en_n,rw,oe_n
  localparam logic [3:0] M_WP   = 4'b0101; // rw low, before write edge
  localparam logic [3:0] M_WR   = 4'b0111; // rw high, commits write
  localparam logic [3:0] M_IDLE = 4'b1111;
  localparam logic [3:0] M_OFF  = 4'b1101; // deselected, rw low
  localparam logic [3:0] M_BADW = 4'b0001;
  localparam logic [3:0] M_BADH = 4'b0011;
  localparam logic [3:0] M_BADR = 4'b0010;
  localparam logic [ADDR_W-4:0] L_HI = 10'h2B3;
  localparam logic [ADDR_W-4:0] R_HI = 10'h11C;

  function automatic logic [7:0] p(input logic [3:0] m, input int a, input logic d);
    return {m, 3'(a), d};
  endfunction

  localparam logic [7:0] ID = 8'hF0;

  // {left pins, right pins, exp left bit, exp left err, exp right bit, exp right err}
  localparam int NV = 32;
  localparam logic [19:0] TBL [NV] = '{
    {p(M_RD,3,0),   p(M_RD,3,0),   4'b1010}, // R2 R4 both see free
    {p(M_WP,3,0),   ID,            4'b0000},
    {p(M_WR,3,0),   p(M_RD,3,0),   4'b0010}, // R6 left takes 3, right sees 1
    {p(M_RD,3,0),   p(M_WP,3,0),   4'b0000}, // R6 owner reads 0
    {p(M_RD,3,0),   p(M_WR,3,0),   4'b0000}, // R7 right request on held flag ignored
    {ID,            p(M_RD,3,0),   4'b0010},
    {ID,            p(M_WP,3,1),   4'b0000},
    {p(M_RD,3,0),   p(M_WR,3,1),   4'b0000}, // R7 non-owner release ignored
    {p(M_WP,3,0),   p(M_RD,3,0),   4'b0010},
    {p(M_WR,3,0),   p(M_RD,3,0),   4'b0010}, // R7 owner re-request ignored
    {p(M_RD,3,0),   ID,            4'b0000}, // R5 rw stays high: no new write
    {p(M_WP,3,1),   ID,            4'b0000},
    {p(M_WR,3,1),   p(M_RD,3,0),   4'b0010}, // R7 owner releases; R3 upper bits zero
    {p(M_RD,3,0),   p(M_WP,5,0),   4'b1000},
    {p(M_WP,5,0),   p(M_WP,5,0),   4'b0000},
    {p(M_WR,5,0),   p(M_WR,5,0),   4'b0000}, // R8 double request
    {p(M_RD,5,0),   p(M_RD,5,0),   4'b0010}, // R8 left wins
    {p(M_WP,1,0),   p(M_WP,6,0),   4'b0000},
    {p(M_WR,1,0),   p(M_WR,6,0),   4'b0000}, // R10 different flags at once
    {p(M_RD,1,0),   p(M_RD,6,0),   4'b0000}, // R10 both granted
    {p(M_RD,6,0),   p(M_RD,1,0),   4'b1010}, // R1 flags independent
    {p(M_WP,1,1),   p(M_WP,1,0),   4'b0000},
    {p(M_WR,1,1),   p(M_WR,1,0),   4'b0000}, // R8 release meets request
    {p(M_RD,1,0),   p(M_RD,1,0),   4'b1010}, // R8 flag left free
    {p(M_BADW,7,0), ID,            4'b0100}, // R9 pulse
    {p(M_BADH,7,0), ID,            4'b0000}, // R9 no repeat, edge rejected
    {ID,            p(M_RD,7,0),   4'b0010}, // R9 flag 7 unchanged
    {p(M_RD,7,0),   p(M_BADR,7,0), 4'b1001}, // R9 right pulse, R4 no data
    {ID,            ID,            4'b0000},
    {p(M_OFF,0,0),  ID,            4'b0000},
    {ID,            p(M_RD,0,0),   4'b0010}, // R5 edge while deselected ignored
    {p(M_RD,0,0),   ID,            4'b1000}
  };

  logic              clk, rst_n;
  logic              l_sem_n, l_mem_en_n, l_rw, l_oe_n, l_err;
  logic              r_sem_n, r_mem_en_n, r_rw, r_oe_n, r_err;
  logic [ADDR_W-1:0] l_addr, r_addr;
  logic [DATA_W-1:0] l_wdata, r_wdata, l_rdata, r_rdata;
  int n_chk, n_fail;

  sem_flag_unit uut (
    .clk(clk), .rst_n(rst_n),
    .l_sem_n(l_sem_n), .l_mem_en_n(l_mem_en_n), .l_rw(l_rw), .l_oe_n(l_oe_n),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_err(l_err),
    .r_sem_n(r_sem_n), .r_mem_en_n(r_mem_en_n), .r_rw(r_rw), .r_oe_n(r_oe_n),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_err(r_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic drive(input logic [7:0] lp, input logic [7:0] rp);
    {l_sem_n, l_mem_en_n, l_rw, l_oe_n} = lp[7:4];
    l_addr  = {L_HI, lp[3:1]};
    l_wdata = {{(DATA_W-1){~lp[0]}}, lp[0]};
    {r_sem_n, r_mem_en_n, r_rw, r_oe_n} = rp[7:4];
    r_addr  = {R_HI, rp[3:1]};
    r_wdata = {{(DATA_W-1){~rp[0]}}, rp[0]};
  endtask

  task automatic check(input string what, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  task automatic write_flag(input bit right, input int a, input logic d);
    drive(right ? ID : p(M_WP,a,d), right ? p(M_WP,a,d) : ID);
    @(negedge clk);
    drive(right ? ID : p(M_WR,a,d), right ? p(M_WR,a,d) : ID);
    @(negedge clk);
    drive(ID, ID);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    n_chk = 0;
    n_fail = 0;
    rst_n = 1'b0;
    drive(ID, ID);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: reset state, all eight flags free from both sides
    check("R2 left err after reset", {15'd0, l_err}, '0);
    check("R2 right err after reset", {15'd0, r_err}, '0);
    for (int i = 0; i < 8; i++) begin
      drive(p(M_RD,i,0), p(M_RD,i,0));
      @(negedge clk);
      check($sformatf("R2 left flag %0d after reset", i), l_rdata, '1);
      check($sformatf("R2 right flag %0d after reset", i), r_rdata, '1);
    end

    // Table walk: drive at negedge, judge one negedge later (after the edge)
    for (int v = 0; v < NV; v++) begin
      logic [7:0] lp, rp;
      logic [3:0] e;
      lp = TBL[v][19:12];
      rp = TBL[v][11:4];
      e  = TBL[v][3:0];
      drive(lp, rp);
      @(negedge clk);
      check($sformatf("R4/table %0d left rdata", v), l_rdata,
            (lp[7:4] == M_RD) ? {DATA_W{e[3]}} : '0);
      check($sformatf("R9/table %0d left err", v), {15'd0, l_err}, {15'd0, e[2]});
      check($sformatf("R4/table %0d right rdata", v), r_rdata,
            (rp[7:4] == M_RD) ? {DATA_W{e[1]}} : '0);
      check($sformatf("R9/table %0d right err", v), {15'd0, r_err}, {15'd0, e[0]});
    end

    // R2: reset while flags 5 (left) and 6 (right) are held frees them
    drive(ID, ID);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    drive(p(M_RD,5,0), p(M_RD,6,0));
    @(negedge clk);
    check("R2 left flag 5 after mid-run reset", l_rdata, '1);
    check("R2 right flag 6 after mid-run reset", r_rdata, '1);

    // R1 R10: left takes even flags, right takes odd flags
    drive(ID, ID);
    @(negedge clk);
    for (int i = 0; i < 8; i++) write_flag(i % 2 == 1, i, 1'b0);
    for (int i = 0; i < 8; i++) begin
      drive(p(M_RD,i,0), p(M_RD,i,0));
      @(negedge clk);
      check($sformatf("R1 left view flag %0d", i), l_rdata, (i % 2 == 0) ? '0 : '1);
      check($sformatf("R1 right view flag %0d", i), r_rdata, (i % 2 == 1) ? '0 : '1);
    end

    summary();
    $finish;
  end
endmodule